// File: doc/BRIEF.md
# Packet Buffer Page Allocator

This block keeps the books for a small packet memory that is split into fixed 256-byte pages. A host drives a command port with three operations: wipe the allocator, request a run of pages for a new packet, and hand the most recently granted packet to the transmit queue. Each granted packet occupies one of a fixed number of packet slots. The slot number is reported back as the packet number. A status flag tells the host that the request has finished, and a separate failed bit marks a request that could not be served.

Allocation runs on its own. A request that is legal and finds a slot, but finds too few free pages, stays pending. It completes on the cycle after enough pages come back. Pages come back when the transmitter reports a successful send and automatic release is switched on. The host sees transmit-completion and allocation-completion status bits. It clears them by writing ones, and a mask register selects which of them drive the interrupt line. A busy flag covers the multi-cycle wipe and the cycle after each allocate or enqueue command, and the block drops any command that arrives while busy is high.

Top module: `pkt_page_alloc`

## Requirements
- R1: After rst_n is released: busy=0, free_pages=16, int_stat=0, irq=0, txq_valid=0, res_fail=0, res_pkt=0.
- R2: Opcode 1 (wipe) sets busy for exactly 4 cycles, starting the cycle after the command edge. It frees every slot, empties the transmit queue, drops any pending request, and clears int_stat, the result and the mask.
- R3: Opcode 2 (allocate) carries cmd_arg = pages-1. When the lowest free slot exists and enough pages are free, the next cycle shows res_pkt = that slot, res_fail=0, free_pages reduced by cmd_arg+1 and int_stat[0]=1.
- R4: An allocate with cmd_arg greater than 7 completes at once with res_fail=1, res_pkt=0 and int_stat[0]=1, and it takes no pages.
- R5: An allocate issued when all 8 slots are taken completes at once with res_fail=1 and res_pkt=0.
- R6: An allocate that lacks free pages stays pending, with no status and no change to the result. It completes in the cycle after the edge that releases enough pages. An allocate issued while one is pending is ignored.
- R7: busy is 1 for exactly one cycle after an accepted allocate (opcode 2) or enqueue (opcode 3). Any command presented while busy=1 is ignored.
- R8: Opcode 3 (enqueue) pushes the packet number of the last successful grant into the transmit queue once. A second enqueue before a new grant is ignored. txq_valid and txq_pkt show the queue head, and txq_pop removes it.
- R9: tx_done with tx_ok=1 while auto_rel=1 returns that packet's pages on the same edge. With tx_ok=0 or auto_rel=0, nothing is freed.
- R10: Every tx_done sets int_stat[1]. Writing a 1 on stat_clr[i] clears int_stat[i], and a set in the same cycle wins over the clear.
- R11: irq is the OR of int_stat & mask. The mask (written by mask_we/mask_in) is 0 after rst_n and after the wipe command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 1 wipe, 2 allocate, 3 enqueue |
| cmd_arg | input | 4 | Page count minus one, for allocate |
| auto_rel | input | 1 | Return pages of successfully sent packets |
| mask_we | input | 1 | Write strobe for the interrupt mask |
| mask_in | input | 2 | New mask value |
| stat_clr | input | 2 | Write-one-to-clear for int_stat |
| tx_done | input | 1 | Transmit completion strobe |
| tx_ok | input | 1 | Completed send succeeded |
| tx_pkt | input | 3 | Packet number of the completed send |
| txq_pop | input | 1 | Remove the transmit queue head |
| busy | output | 1 | Commands are being refused |
| res_pkt | output | 3 | Packet number granted by the last finished request |
| res_fail | output | 1 | Last finished request failed |
| int_stat | output | 2 | Bit 0 allocation done, bit 1 transmit done |
| irq | output | 1 | Masked interrupt |
| free_pages | output | 5 | Count of unallocated pages |
| txq_valid | output | 1 | Transmit queue not empty |
| txq_pkt | output | 3 | Packet number at the queue head |

## Verification
Slot bookkeeping can go wrong without any immediate sign on the ports. A slot marked used or free in error, or a wrong page span stored for it, changes free_pages on the same edge for grants and releases. It also changes res_pkt on the next grant, because the lowest free slot is chosen, so the bench compares both after every command. A pending request that is lost or replaced shows up only when pages return. The bench therefore releases pages under a pending request and expects completion exactly one cycle later, with the original page count. A stuck busy counter or command latch shows as a wrong busy length and as commands that are dropped or taken one cycle off.

// File: rtl/pa_pkg.sv
package pa_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_WIPE  = 2'd1,
    OP_ALLOC = 2'd2,
    OP_ENQ   = 2'd3
  } pa_op_e;
endpackage

// File: rtl/pa_slot_table.sv
module pa_slot_table #(
  parameter int NUM_SLOTS = 8,
  parameter int NUM_PAGES = 16,
  parameter int FIELD_W   = 4,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int PG_W   = $clog2(NUM_PAGES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               grant,
  input  logic [FIELD_W-1:0] grant_field,
  input  logic               rel,
  input  logic [SLOT_W-1:0]  rel_slot,
  output logic [PG_W-1:0]    free_cnt,
  output logic [SLOT_W-1:0]  free_slot,
  output logic               have_slot
);
  logic [NUM_SLOTS-1:0] used;
  logic [PG_W-1:0]      span [NUM_SLOTS];
  logic [PG_W-1:0]      taken;

  function automatic logic [PG_W-1:0] pages_of(input logic [FIELD_W-1:0] f);
    return PG_W'(f) + PG_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used <= '0;
      for (int s = 0; s < NUM_SLOTS; s++) span[s] <= '0;
    end else if (clr) begin
      used <= '0;
    end else begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        if (grant && free_slot == SLOT_W'(s)) begin
          used[s] <= 1'b1;
          span[s] <= pages_of(grant_field);
        end else if (rel && rel_slot == SLOT_W'(s)) begin
          used[s] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    taken     = '0;
    free_slot = '0;
    for (int s = 0; s < NUM_SLOTS; s++)
      if (used[s]) taken = taken + span[s];
    for (int s = NUM_SLOTS - 1; s >= 0; s--)
      if (!used[s]) free_slot = SLOT_W'(s);
  end

  assign have_slot = ~&used;
  assign free_cnt  = PG_W'(NUM_PAGES) - taken;
endmodule

// File: rtl/pa_tx_fifo.sv
module pa_tx_fifo #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 3,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic              valid,
  output logic              full,
  output logic [DATA_W-1:0] head
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count;
  logic              do_push, do_pop;

  assign valid   = count != '0;
  assign full    = count == CNT_W'(DEPTH);
  assign do_push = push & ~full;
  assign do_pop  = pop & valid;
  assign head    = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) begin
        mem[wr_ptr] <= push_data;
        wr_ptr      <= step(wr_ptr);
      end
      if (do_pop) rd_ptr <= step(rd_ptr);
      count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end
endmodule

// File: rtl/pkt_page_alloc.sv
module pkt_page_alloc #(
  parameter int NUM_SLOTS  = 8,
  parameter int NUM_PAGES  = 16,
  parameter int FIELD_W    = 4,
  parameter int MAX_FIELD  = 7,
  parameter int WIPE_CYC   = 4,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int PG_W   = $clog2(NUM_PAGES + 1),
  localparam int WC_W   = $clog2(WIPE_CYC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd_op,
  input  logic [FIELD_W-1:0] cmd_arg,
  input  logic               auto_rel,
  input  logic               mask_we,
  input  logic [1:0]         mask_in,
  input  logic [1:0]         stat_clr,
  input  logic               tx_done,
  input  logic               tx_ok,
  input  logic [SLOT_W-1:0]  tx_pkt,
  input  logic               txq_pop,
  output logic               busy,
  output logic [SLOT_W-1:0]  res_pkt,
  output logic               res_fail,
  output logic [1:0]         int_stat,
  output logic               irq,
  output logic [PG_W-1:0]    free_pages,
  output logic               txq_valid,
  output logic [SLOT_W-1:0]  txq_pkt
);
  import pa_pkg::*;

  pa_op_e             op;
  logic [WC_W-1:0]    wipe_cnt;
  logic               cmd_hold;
  logic               accept, cmd_take, wipe_cmd, alloc_cmd, enq_cmd;
  logic               pend, req_on, fits, grant_evt, fail_evt;
  logic [FIELD_W-1:0] pend_f, req_f;
  logic               enq_ok, q_full, q_push, rel_evt;
  logic [1:0]         mask;
  logic [SLOT_W-1:0]  free_slot;
  logic               have_slot;

  function automatic logic [PG_W-1:0] pages_of(input logic [FIELD_W-1:0] f);
    return PG_W'(f) + PG_W'(1);
  endfunction

  function automatic logic too_big(input logic [FIELD_W-1:0] f);
    return f > FIELD_W'(MAX_FIELD);
  endfunction

  assign op        = pa_op_e'(cmd_op);
  assign busy      = (wipe_cnt != '0) | cmd_hold;
  assign accept    = cmd_valid & ~busy;
  assign cmd_take  = accept & (op == OP_ALLOC || op == OP_ENQ);
  assign wipe_cmd  = accept & (op == OP_WIPE);
  assign alloc_cmd = accept & (op == OP_ALLOC) & ~pend;
  assign enq_cmd   = accept & (op == OP_ENQ);

  assign req_on    = alloc_cmd | pend;
  assign req_f     = alloc_cmd ? cmd_arg : pend_f;
  assign fail_evt  = alloc_cmd & (too_big(cmd_arg) | ~have_slot);
  assign fits      = pages_of(req_f) <= free_pages;
  assign grant_evt = req_on & ~fail_evt & fits & have_slot & ~wipe_cmd;
  assign rel_evt   = tx_done & tx_ok & auto_rel & ~wipe_cmd;
  assign q_push    = enq_cmd & enq_ok & ~q_full;

  pa_slot_table #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_PAGES(NUM_PAGES), .FIELD_W(FIELD_W)
  ) i_slots (
    .clk, .rst_n,
    .clr         (wipe_cmd),
    .grant       (grant_evt),
    .grant_field (req_f),
    .rel         (rel_evt),
    .rel_slot    (tx_pkt),
    .free_cnt    (free_pages),
    .free_slot   (free_slot),
    .have_slot   (have_slot)
  );

  pa_tx_fifo #(.DEPTH(NUM_SLOTS), .DATA_W(SLOT_W)) i_txq (
    .clk, .rst_n,
    .clr       (wipe_cmd),
    .push      (q_push),
    .push_data (res_pkt),
    .pop       (txq_pop),
    .valid     (txq_valid),
    .full      (q_full),
    .head      (txq_pkt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wipe_cnt <= '0;
      cmd_hold <= 1'b0;
      pend     <= 1'b0;
      pend_f   <= '0;
      res_pkt  <= '0;
      res_fail <= 1'b0;
      enq_ok   <= 1'b0;
      int_stat <= '0;
      mask     <= '0;
    end else if (wipe_cmd) begin
      wipe_cnt <= WC_W'(WIPE_CYC);
      cmd_hold <= 1'b0;
      pend     <= 1'b0;
      res_pkt  <= '0;
      res_fail <= 1'b0;
      enq_ok   <= 1'b0;
      int_stat <= '0;
      mask     <= '0;
    end else begin
      if (wipe_cnt != '0) wipe_cnt <= wipe_cnt - WC_W'(1);
      cmd_hold <= cmd_take;
      if (grant_evt || fail_evt) pend <= 1'b0;
      else if (alloc_cmd) begin
        pend   <= 1'b1;
        pend_f <= cmd_arg;
      end
      if (grant_evt) begin
        res_pkt  <= free_slot;
        res_fail <= 1'b0;
        enq_ok   <= 1'b1;
      end else if (fail_evt) begin
        res_pkt  <= '0;
        res_fail <= 1'b1;
        enq_ok   <= 1'b0;
      end else if (q_push) begin
        enq_ok   <= 1'b0;
      end
      int_stat <= (int_stat & ~stat_clr) | {tx_done, grant_evt | fail_evt};
      if (mask_we) mask <= mask_in;
    end
  end

  assign irq = |(int_stat & mask);
endmodule

// File: rtl/pa_checker.sv
module pa_checker #(
  parameter int NUM_PAGES = 16,
  parameter int SLOT_W    = 3,
  parameter int PG_W      = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_take,
  input logic              wipe_cmd,
  input logic              grant_evt,
  input logic              fail_evt,
  input logic              busy,
  input logic              res_fail,
  input logic [SLOT_W-1:0] res_pkt,
  input logic [1:0]        int_stat,
  input logic              irq,
  input logic [PG_W-1:0]   free_pages
);
  // R7: accepted allocate/enqueue holds off the next cycle
  a_r7_busy_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_take |=> busy);
  // R2: wipe raises busy
  a_r2_wipe_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wipe_cmd |=> busy);
  // R11: mask is cleared by wipe, so no interrupt right after it
  a_r11_wipe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    wipe_cmd |=> !irq);
  // R3: a grant reports success and sets the completion flag
  a_r3_grant_flag: assert property (@(posedge clk) disable iff (!rst_n)
    grant_evt |=> (int_stat[0] && !res_fail));
  // R4/R5: a failed request flags failure with packet zero
  a_r4_fail_result: assert property (@(posedge clk) disable iff (!rst_n)
    fail_evt |=> (res_fail && res_pkt == '0 && int_stat[0]));
  // R3: the free count never exceeds the pool
  a_r3_pool_bound: assert property (@(posedge clk) disable iff (!rst_n)
    free_pages <= PG_W'(NUM_PAGES));
endmodule

bind pkt_page_alloc pa_checker #(
  .NUM_PAGES(NUM_PAGES), .SLOT_W(SLOT_W), .PG_W(PG_W)
) i_pa_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_take   (cmd_take),
  .wipe_cmd   (wipe_cmd),
  .grant_evt  (grant_evt),
  .fail_evt   (fail_evt),
  .busy       (busy),
  .res_fail   (res_fail),
  .res_pkt    (res_pkt),
  .int_stat   (int_stat),
  .irq        (irq),
  .free_pages (free_pages)
);

// File: tb/test_pkt_page_alloc.sv
module test_pkt_page_alloc;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [3:0] cmd_arg = 4'd0;
  logic       auto_rel = 1'b1;
  logic       mask_we = 1'b0;
  logic [1:0] mask_in = 2'd0;
  logic [1:0] stat_clr = 2'd0;
  logic       tx_done = 1'b0;
  logic       tx_ok = 1'b0;
  logic [2:0] tx_pkt = 3'd0;
  logic       txq_pop = 1'b0;
  logic       busy, res_fail, irq, txq_valid;
  logic [2:0] res_pkt, txq_pkt;
  logic [1:0] int_stat;
  logic [4:0] free_pages;

  int n_run = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  pkt_page_alloc i_pkt_page_alloc (
    .clk, .rst_n, .cmd_valid, .cmd_op, .cmd_arg, .auto_rel, .mask_we, .mask_in,
    .stat_clr, .tx_done, .tx_ok, .tx_pkt, .txq_pop, .busy, .res_pkt, .res_fail,
    .int_stat, .irq, .free_pages, .txq_valid, .txq_pkt
  );

  typedef struct packed {
    logic [3:0] arg;
    logic       flag;
    logic       fail;
    logic [2:0] pkt;
    logic [4:0] free;
  } vec_t;

  // Pages requested = arg+1; pool 16 pages; lowest free slot granted.
  localparam vec_t VEC [6] = '{
    '{4'd0, 1'b1, 1'b0, 3'd0, 5'd15},
    '{4'd2, 1'b1, 1'b0, 3'd1, 5'd12},
    '{4'd8, 1'b1, 1'b1, 3'd0, 5'd12},
    '{4'd7, 1'b1, 1'b0, 3'd2, 5'd4},
    '{4'd3, 1'b1, 1'b0, 3'd3, 5'd0},
    '{4'd0, 1'b0, 1'b0, 3'd3, 5'd0}
  };

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  task automatic check(input string tag, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cmd(input logic [1:0] op, input logic [3:0] arg);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_arg   = arg;
    tick();
    cmd_valid = 1'b0;
  endtask

  task automatic send_done(input logic [2:0] p, input logic ok);
    tx_done = 1'b1;
    tx_ok   = ok;
    tx_pkt  = p;
    tick();
    tx_done = 1'b0;
    tx_ok   = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got %0d expected below 20000", cycles);
        summary();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 free", free_pages, 16);
    check("R1 stat", int_stat, 0);
    check("R1 irq", irq, 0);
    check("R1 txq", txq_valid, 0);
    check("R1 result", {res_fail, res_pkt}, 0);

    // R3 R4 R6 vector walk
    foreach (VEC[i]) begin
      stat_clr = 2'b11;
      tick();
      stat_clr = 2'b00;
      cmd(2'd2, VEC[i].arg);
      check("R3/R4/R6 flag", int_stat[0], VEC[i].flag);
      check("R3/R4 fail", res_fail, VEC[i].fail);
      check("R3/R4 pkt", res_pkt, VEC[i].pkt);
      check("R3/R4 free", free_pages, VEC[i].free);
    end
    tick();

    // R8 enqueue last grant (packet 3)
    cmd(2'd3, 4'd0);
    check("R8 txq valid", txq_valid, 1);
    check("R8 txq pkt", txq_pkt, 3);
    tick();

    // R9 release of packet 3, then R6 pending completes next cycle
    send_done(3'd3, 1'b1);
    check("R9 free after release", free_pages, 4);
    check("R6 still pending", int_stat[0], 0);
    check("R10 tx flag", int_stat[1], 1);
    tick();
    check("R6 completes pkt", res_pkt, 3);
    check("R6 completes flag", int_stat[0], 1);
    check("R6 completes free", free_pages, 3);

    // R8 single push per grant
    txq_pop = 1'b1; tick(); txq_pop = 1'b0;
    check("R8 pop empties", txq_valid, 0);
    cmd(2'd3, 4'd0);
    check("R8 re-push", txq_valid, 1);
    tick();
    cmd(2'd3, 4'd0);
    tick();
    txq_pop = 1'b1; tick(); txq_pop = 1'b0;
    check("R8 second enqueue ignored", txq_valid, 0);

    // R9 no release when disabled or unsuccessful
    auto_rel = 1'b0;
    send_done(3'd2, 1'b1);
    check("R9 auto off", free_pages, 3);
    auto_rel = 1'b1;
    send_done(3'd2, 1'b0);
    check("R9 tx not ok", free_pages, 3);

    // R10 write-one-to-clear and set priority
    stat_clr = 2'b10; tick(); stat_clr = 2'b00;
    check("R10 clear", int_stat[1], 0);
    stat_clr = 2'b10;
    send_done(3'd2, 1'b0);
    stat_clr = 2'b00;
    check("R10 set wins", int_stat[1], 1);

    // R11 mask gating
    check("R11 masked", irq, 0);
    mask_we = 1'b1; mask_in = 2'b10; tick(); mask_we = 1'b0;
    check("R11 unmasked", irq, 1);
    stat_clr = 2'b11; tick(); stat_clr = 2'b00;
    check("R11 cleared", irq, 0);

    // R7 busy window and command refused while busy
    cmd(2'd2, 4'd0);
    check("R7 busy", busy, 1);
    check("R7 grant", res_pkt, 4);
    check("R7 free", free_pages, 2);
    cmd(2'd2, 4'd0);
    check("R7 busy one cycle", busy, 0);
    check("R7 ignored free", free_pages, 2);
    check("R7 ignored pkt", res_pkt, 4);

    // R2 wipe
    mask_we = 1'b1; mask_in = 2'b11; tick(); mask_we = 1'b0;
    check("R11 irq before wipe", irq, 1);
    cmd(2'd1, 4'd0);
    check("R2 busy c1", busy, 1);
    cmd(2'd2, 4'd0);
    check("R2 busy c2", busy, 1);
    tick();
    check("R2 busy c3", busy, 1);
    tick();
    check("R2 busy c4", busy, 1);
    tick();
    check("R2 busy end", busy, 0);
    check("R2 free", free_pages, 16);
    check("R2 stat", int_stat, 0);
    check("R2 result", {res_fail, res_pkt}, 0);
    check("R2 txq", txq_valid, 0);
    send_done(3'd0, 1'b0);
    check("R11 mask cleared by wipe", irq, 0);

    // R5 slot exhaustion
    for (int k = 0; k < 8; k++) begin
      cmd(2'd2, 4'd0);
      check("R5 fill pkt", res_pkt, k);
      tick();
    end
    check("R5 free", free_pages, 8);
    cmd(2'd2, 4'd0);
    check("R5 fail", res_fail, 1);
    check("R5 fail pkt", res_pkt, 0);
    check("R5 fail free", free_pages, 8);
    tick();

    // R6 second allocate while pending is ignored
    cmd(2'd1, 4'd0);
    repeat (4) tick();
    cmd(2'd2, 4'd7); tick();
    cmd(2'd2, 4'd7); tick();
    check("R6 pool empty", free_pages, 0);
    cmd(2'd2, 4'd1); tick();
    cmd(2'd2, 4'd0); tick();
    check("R6 pending result", res_pkt, 1);
    send_done(3'd0, 1'b1);
    check("R6 pages back", free_pages, 8);
    tick();
    check("R6 orig request pkt", res_pkt, 0);
    check("R6 orig request free", free_pages, 6);
    check("R6 orig request ok", res_fail, 0);

    summary();
  end
endmodule